// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital front end of a successive-approximation converter. It owns the power state of the converter core and waits a fixed number of conversion-clock ticks for the core to settle. It then accepts conversion requests for two groups: a regular group with one result register, and an injected group with four result registers that are filled in order. The conversion clock reaches the block only as a clock-enable pulse, `cke_i`, so the rest of the logic runs on the bus clock.

A single enable bit has three jobs. The first write of 1 while powered down only powers the core up and starts the settling wait. Each later write of 1 starts a regular conversion. A write of 0 aborts any conversion in flight and powers the core down. Each group has its own software start, its own 3-bit external trigger select and its own external-trigger enable. The analog core is modelled as a start pulse followed by a done pulse that carries the result.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `powered_o`, `ready_o`, `busy_o`, `eoc_o` and `jeoc_o` are 0, and all data outputs are 0.
- R2: A write of 1 to the enable bit while powered down sets `powered_o` and starts no conversion. `ready_o` rises after exactly `STAB_CYCLES` cycles in which `cke_i` is high, and cycles with `cke_i` low do not count.
- R3: A start request of any kind that arrives before `ready_o` is high is dropped. No conversion follows it once the block is ready.
- R4: While `ready_o` is high, a write of 1 to the enable bit starts a regular conversion. The core result is stored zero-extended in `reg_data_o`, and `eoc_o` is set.
- R5: A write of 0 to the enable bit clears `powered_o`, `ready_o` and `busy_o` on the next edge. A conversion that was in flight then sets no flag and writes no register.
- R6: A regular external trigger is a rising edge on `reg_trig_i[reg_sel_i]`, and it is accepted only while `reg_ext_en_i` is 1. A level held high starts one conversion. Edges on other bits start none.
- R7: An injected request, made by `inj_sw_start_i` or by a rising edge on `inj_trig_i[inj_sel_i]` while `inj_ext_en_i` is 1, runs `inj_len_i`+1 conversions. Conversion k writes injected slot k, which is `inj_data_o[16k+15:16k]`. `jeoc_o` is set after the last one.
- R8: An injected request that arrives during a regular conversion is held. It is served after that conversion ends and before a regular request that is also pending.
- R9: `eoc_o` and `jeoc_o` stay set until cleared. `eoc_o` is cleared by `eoc_clr_i` or `reg_rd_i`, and `jeoc_o` by `jeoc_clr_i` or `inj_rd_i`. A completion in the same cycle as a clear leaves the flag set.
- R10: `conv_start_o` is a one-cycle pulse for each conversion. During the conversion, `conv_inj_o` shows the group (1 for injected) and `conv_idx_o` shows the injected slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cke_i | input | 1 | Conversion-clock tick enable |
| en_wr_i | input | 1 | Write strobe for the enable bit |
| en_wdata_i | input | 1 | Value written to the enable bit |
| reg_sw_start_i | input | 1 | Regular software start strobe |
| inj_sw_start_i | input | 1 | Injected software start strobe |
| reg_ext_en_i | input | 1 | Regular external-trigger enable |
| inj_ext_en_i | input | 1 | Injected external-trigger enable |
| reg_sel_i | input | 3 | Regular trigger source select |
| inj_sel_i | input | 3 | Injected trigger source select |
| reg_trig_i | input | 8 | Regular trigger sources |
| inj_trig_i | input | 8 | Injected trigger sources |
| inj_len_i | input | 2 | Injected sequence length minus one |
| eoc_clr_i | input | 1 | Write-one-to-clear for the regular flag |
| jeoc_clr_i | input | 1 | Write-one-to-clear for the injected flag |
| reg_rd_i | input | 1 | Read strobe of the regular data register |
| inj_rd_i | input | 1 | Read strobe of an injected data register |
| core_done_i | input | 1 | Core conversion done pulse |
| core_data_i | input | 10 | Core conversion result |
| conv_start_o | output | 1 | Core conversion start pulse |
| conv_inj_o | output | 1 | Current conversion is injected |
| conv_idx_o | output | 2 | Current injected slot |
| powered_o | output | 1 | Core powered up |
| ready_o | output | 1 | Settling wait complete |
| busy_o | output | 1 | Conversion sequence in progress |
| eoc_o | output | 1 | Regular end-of-conversion flag |
| jeoc_o | output | 1 | Injected end-of-conversion flag |
| reg_data_o | output | 16 | Regular data register |
| inj_data_o | output | 64 | Four injected data registers, slot 0 in the low bits |

## Verification
The set of an end-of-conversion flag by a completing conversion can fall in the same cycle as a write-one-to-clear of that flag. The bench provokes this by watching `core_done_i` from its core model and raising `eoc_clr_i` in exactly the cycle in which the done pulse is present. It then judges that the flag is still set afterwards and that the data register holds the new result. A later clear is checked separately to confirm that the flag does drop when no completion competes with it.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {PWR_OFF, PWR_STAB, PWR_ON} pwr_st_e;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_REG, SEQ_INJ} seq_st_e;
endpackage

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl
  import adc_seq_pkg::*;
#(
  parameter int STAB_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cke_i,
  input  logic en_wr_i,
  input  logic en_wdata_i,
  output logic powered_o,
  output logic ready_o,
  output logic sw_start_o,
  output logic abort_o
);
  localparam int CNT_W = $clog2(STAB_CYCLES + 1);

  pwr_st_e            st_q;
  logic [CNT_W-1:0]   cnt_q;

  assign abort_o    = en_wr_i & ~en_wdata_i;
  assign sw_start_o = en_wr_i & en_wdata_i & (st_q == PWR_ON);
  assign powered_o  = (st_q != PWR_OFF);
  assign ready_o    = (st_q == PWR_ON);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PWR_OFF;
      cnt_q <= '0;
    end else if (abort_o) begin
      st_q  <= PWR_OFF;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        PWR_OFF: if (en_wr_i && en_wdata_i) begin
          st_q  <= PWR_STAB;
          cnt_q <= CNT_W'(STAB_CYCLES);
        end
        PWR_STAB: if (cke_i) begin
          if (cnt_q <= CNT_W'(1)) st_q <= PWR_ON;
          else                    cnt_q <= cnt_q - CNT_W'(1);
        end
        default: st_q <= PWR_ON;
      endcase
    end
  end
endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
  parameter int N_SRC = 8,
  parameter int SEL_W = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] trig_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             ext_en_i,
  input  logic             sw_i,
  output logic             req_o
);
  logic [N_SRC-1:0] prev_q;

  // every source keeps its own history so a select change makes no false edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= trig_i;
  end

  assign req_o = sw_i | (ext_en_i & trig_i[sel_i] & ~prev_q[sel_i]);
endmodule

// File: rtl/adc_conv_fsm.sv
module adc_conv_fsm
  import adc_seq_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             reg_req_i,
  input  logic             inj_req_i,
  input  logic [IDX_W-1:0] inj_len_i,
  input  logic             core_done_i,
  output logic             conv_start_o,
  output logic             conv_inj_o,
  output logic [IDX_W-1:0] conv_idx_o,
  output logic             busy_o,
  output logic             reg_wr_o,
  output logic             inj_wr_o,
  output logic             inj_last_o
);
  seq_st_e          st_q;
  logic             reg_pend_q, inj_pend_q, start_q;
  logic [IDX_W-1:0] idx_q;

  assign conv_start_o = start_q;
  assign conv_inj_o   = (st_q == SEQ_INJ);
  assign conv_idx_o   = idx_q;
  assign busy_o       = (st_q != SEQ_IDLE);
  assign reg_wr_o     = run_i & core_done_i & (st_q == SEQ_REG);
  assign inj_wr_o     = run_i & core_done_i & (st_q == SEQ_INJ);
  assign inj_last_o   = inj_wr_o & (idx_q == inj_len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= SEQ_IDLE;
      reg_pend_q <= 1'b0;
      inj_pend_q <= 1'b0;
      start_q    <= 1'b0;
      idx_q      <= '0;
    end else if (!run_i) begin
      st_q       <= SEQ_IDLE;
      reg_pend_q <= 1'b0;
      inj_pend_q <= 1'b0;
      start_q    <= 1'b0;
      idx_q      <= '0;
    end else begin
      start_q    <= 1'b0;
      reg_pend_q <= reg_pend_q | reg_req_i;
      inj_pend_q <= inj_pend_q | inj_req_i;
      unique case (st_q)
        SEQ_IDLE: begin
          // injected group wins over a pending regular request
          if (inj_pend_q) begin
            st_q       <= SEQ_INJ;
            idx_q      <= '0;
            start_q    <= 1'b1;
            inj_pend_q <= inj_req_i;
          end else if (reg_pend_q) begin
            st_q       <= SEQ_REG;
            start_q    <= 1'b1;
            reg_pend_q <= reg_req_i;
          end
        end
        SEQ_REG: if (core_done_i) st_q <= SEQ_IDLE;
        SEQ_INJ: if (core_done_i) begin
          if (idx_q == inj_len_i) begin
            st_q  <= SEQ_IDLE;
            idx_q <= '0;
          end else begin
            idx_q   <= idx_q + IDX_W'(1);
            start_q <= 1'b1;
          end
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int STAB_CYCLES = 16,
  parameter int N_SRC       = 8,
  parameter int SEL_W       = $clog2(N_SRC),
  parameter int INJ_N       = 4,
  parameter int IDX_W       = $clog2(INJ_N),
  parameter int RES_W       = 10,
  parameter int DATA_W      = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cke_i,
  input  logic                    en_wr_i,
  input  logic                    en_wdata_i,
  input  logic                    reg_sw_start_i,
  input  logic                    inj_sw_start_i,
  input  logic                    reg_ext_en_i,
  input  logic                    inj_ext_en_i,
  input  logic [SEL_W-1:0]        reg_sel_i,
  input  logic [SEL_W-1:0]        inj_sel_i,
  input  logic [N_SRC-1:0]        reg_trig_i,
  input  logic [N_SRC-1:0]        inj_trig_i,
  input  logic [IDX_W-1:0]        inj_len_i,
  input  logic                    eoc_clr_i,
  input  logic                    jeoc_clr_i,
  input  logic                    reg_rd_i,
  input  logic                    inj_rd_i,
  input  logic                    core_done_i,
  input  logic [RES_W-1:0]        core_data_i,
  output logic                    conv_start_o,
  output logic                    conv_inj_o,
  output logic [IDX_W-1:0]        conv_idx_o,
  output logic                    powered_o,
  output logic                    ready_o,
  output logic                    busy_o,
  output logic                    eoc_o,
  output logic                    jeoc_o,
  output logic [DATA_W-1:0]       reg_data_o,
  output logic [INJ_N*DATA_W-1:0] inj_data_o
);
  logic pwr_sw_start, abort, run;
  logic reg_req_ext, inj_req, reg_req;
  logic reg_wr, inj_wr, inj_last;

  adc_pwr_ctrl #(.STAB_CYCLES(STAB_CYCLES)) u_pwr (
    .clk_i, .rst_ni, .cke_i, .en_wr_i, .en_wdata_i,
    .powered_o, .ready_o, .sw_start_o(pwr_sw_start), .abort_o(abort)
  );

  assign run = ready_o & ~abort;

  adc_trig_edge #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_reg_trig (
    .clk_i, .rst_ni, .trig_i(reg_trig_i), .sel_i(reg_sel_i),
    .ext_en_i(reg_ext_en_i), .sw_i(reg_sw_start_i), .req_o(reg_req_ext)
  );

  adc_trig_edge #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_inj_trig (
    .clk_i, .rst_ni, .trig_i(inj_trig_i), .sel_i(inj_sel_i),
    .ext_en_i(inj_ext_en_i), .sw_i(inj_sw_start_i), .req_o(inj_req)
  );

  assign reg_req = reg_req_ext | pwr_sw_start;

  adc_conv_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk_i, .rst_ni, .run_i(run), .reg_req_i(reg_req), .inj_req_i(inj_req),
    .inj_len_i, .core_done_i, .conv_start_o, .conv_inj_o, .conv_idx_o,
    .busy_o, .reg_wr_o(reg_wr), .inj_wr_o(inj_wr), .inj_last_o(inj_last)
  );

  // set beats clear on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eoc_o      <= 1'b0;
      jeoc_o     <= 1'b0;
      reg_data_o <= '0;
    end else begin
      if (reg_wr) begin
        eoc_o      <= 1'b1;
        reg_data_o <= DATA_W'(core_data_i);
      end else if (eoc_clr_i || reg_rd_i) begin
        eoc_o <= 1'b0;
      end
      if (inj_last)                     jeoc_o <= 1'b1;
      else if (jeoc_clr_i || inj_rd_i)  jeoc_o <= 1'b0;
    end
  end

  for (genvar g = 0; g < INJ_N; g++) begin : g_inj_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  slot_q <= '0;
      else if (inj_wr && conv_idx_o == IDX_W'(g))   slot_q <= DATA_W'(core_data_i);
    end
    assign inj_data_o[g*DATA_W +: DATA_W] = slot_q;
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_wr_i,
  input logic en_wdata_i,
  input logic eoc_clr_i,
  input logic jeoc_clr_i,
  input logic reg_rd_i,
  input logic inj_rd_i,
  input logic conv_start_o,
  input logic powered_o,
  input logic ready_o,
  input logic busy_o,
  input logic eoc_o,
  input logic jeoc_o
);
  AST_POWERUP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(powered_o) |-> (!busy_o && !ready_o)); // R2
  AST_START_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> ready_o); // R3
  AST_ABORT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_wr_i && !en_wdata_i) |=> (!powered_o && !busy_o)); // R5
  AST_BUSY_POWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> powered_o); // R5
  AST_EOC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoc_o && !eoc_clr_i && !reg_rd_i) |=> eoc_o); // R9
  AST_JEOC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jeoc_o && !jeoc_clr_i && !inj_rd_i) |=> jeoc_o); // R9
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (.*);

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cke, en_wr, en_wdata, reg_sw, inj_sw, reg_xen, inj_xen;
  logic [2:0] reg_sel, inj_sel;
  logic [7:0] reg_trig, inj_trig;
  logic [1:0] inj_len;
  logic eoc_clr, jeoc_clr, reg_rd, inj_rd;
  logic core_done;
  logic [9:0] core_data;
  logic conv_start, conv_inj, powered, ready, busy, eoc, jeoc;
  logic [1:0] conv_idx;
  logic [15:0] reg_data;
  logic [63:0] inj_data;

  int vectors = 0, fails = 0, starts = 0, wide = 0, mcnt = 0;
  logic start_prev = 1'b0;
  logic [6:0] mseq;

  always #2 clk = ~clk;

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .en_wr_i(en_wr), .en_wdata_i(en_wdata),
    .reg_sw_start_i(reg_sw), .inj_sw_start_i(inj_sw), .reg_ext_en_i(reg_xen),
    .inj_ext_en_i(inj_xen), .reg_sel_i(reg_sel), .inj_sel_i(inj_sel),
    .reg_trig_i(reg_trig), .inj_trig_i(inj_trig), .inj_len_i(inj_len),
    .eoc_clr_i(eoc_clr), .jeoc_clr_i(jeoc_clr), .reg_rd_i(reg_rd), .inj_rd_i(inj_rd),
    .core_done_i(core_done), .core_data_i(core_data), .conv_start_o(conv_start),
    .conv_inj_o(conv_inj), .conv_idx_o(conv_idx), .powered_o(powered), .ready_o(ready),
    .busy_o(busy), .eoc_o(eoc), .jeoc_o(jeoc), .reg_data_o(reg_data), .inj_data_o(inj_data)
  );

  // core model: result = {injected, slot, sequence number}, done 4 cycles after start
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_done <= 1'b0; core_data <= '0; mseq <= '0; mcnt <= 0;
    end else begin
      core_done <= 1'b0;
      if (conv_start) begin
        mcnt <= 4; mseq <= mseq + 7'd1; core_data <= {conv_inj, conv_idx, mseq};
      end else if (mcnt == 1) begin
        core_done <= 1'b1; mcnt <= 0;
      end else if (mcnt > 1) mcnt <= mcnt - 1;
    end
  end

  always @(posedge clk) begin
    if (conv_start) starts <= starts + 1;
    if (conv_start && start_prev) wide <= wide + 1;
    start_prev <= conv_start;
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_en(input logic v);
    en_wr = 1'b1; en_wdata = v; cyc(1); en_wr = 1'b0;
  endtask

  task automatic pulse_clr();
    eoc_clr = 1'b1; jeoc_clr = 1'b1; cyc(1); eoc_clr = 1'b0; jeoc_clr = 1'b0;
  endtask

  task automatic wait_flag(input bit inj, input string req);
    for (int i = 0; i < 300; i++) begin
      if ((inj ? jeoc : eoc) === 1'b1) return;
      cyc(1);
    end
    chk(req, "flag never set", 0, 1);
  endtask

  task automatic t_reset();
    chk("R1", "powered", powered, 0); chk("R1", "ready", ready, 0);
    chk("R1", "busy", busy, 0); chk("R1", "eoc", eoc, 0); chk("R1", "jeoc", jeoc, 0);
    chk("R1", "reg_data", reg_data, 0); chk("R1", "inj_data", inj_data, 0);
  endtask

  task automatic t_powerup();
    int s0;
    s0 = starts;
    wr_en(1'b1);
    chk("R2", "powered after enable", powered, 1);
    chk("R2", "ready right after enable", ready, 0);
    chk("R2", "no conversion on power-up", busy, 0);
    reg_sw = 1'b1; inj_sw = 1'b1; cyc(1); reg_sw = 1'b0; inj_sw = 1'b0;
    wr_en(1'b1);
    cke = 1'b0; cyc(20);
    chk("R2", "ready with cke low", ready, 0);
    cke = 1'b1; cyc(13);
    chk("R2", "ready one tick early", ready, 0);
    cyc(1);
    chk("R2", "ready after STAB_CYCLES ticks", ready, 1);
    cyc(20);
    chk("R3", "starts from requests during settling", starts - s0, 0);
    chk("R3", "busy after ignored requests", busy, 0);
    chk("R3", "eoc after ignored requests", eoc, 0);
  endtask

  task automatic t_sw_start();
    int s0;
    s0 = starts;
    wr_en(1'b1);
    wait_flag(1'b0, "R4");
    chk("R4", "reg_data", reg_data, 64'(s0[6:0]));
    chk("R10", "one start per conversion", starts - s0, 1);
    chk("R10", "start pulse width", wide, 0);
    pulse_clr();
  endtask

  task automatic t_ext_trig();
    int s0;
    s0 = starts;
    reg_sel = 3'd3; reg_xen = 1'b0;
    reg_trig[3] = 1'b1; cyc(2); reg_trig[3] = 1'b0; cyc(10);
    chk("R6", "trigger with enable off", starts - s0, 0);
    reg_xen = 1'b1;
    reg_trig[2] = 1'b1; cyc(2); reg_trig[2] = 1'b0; cyc(10);
    chk("R6", "edge on unselected source", starts - s0, 0);
    reg_trig[3] = 1'b1;
    wait_flag(1'b0, "R6");
    cyc(20);
    chk("R6", "level held gives one conversion", starts - s0, 1);
    chk("R6", "reg_data", reg_data, 64'(s0[6:0]));
    reg_trig[3] = 1'b0; reg_xen = 1'b0;
    pulse_clr();
  endtask

  task automatic t_inj_seq();
    int s0;
    s0 = starts;
    inj_sel = 3'd5; inj_xen = 1'b1; inj_len = 2'd3;
    inj_trig[5] = 1'b1; cyc(1); inj_trig[5] = 1'b0;
    wait_flag(1'b1, "R7");
    chk("R7", "injected conversion count", starts - s0, 4);
    for (int k = 0; k < 4; k++)
      chk("R7", $sformatf("slot %0d", k), inj_data[k*16 +: 16],
          64'({1'b1, 2'(k), 7'(s0 + k)}));
    chk("R7", "regular flag untouched", eoc, 0);
    inj_xen = 1'b0;
    pulse_clr();
  endtask

  task automatic t_inj_during_reg();
    int s0;
    s0 = starts;
    inj_len = 2'd0;
    reg_sw = 1'b1; cyc(1); reg_sw = 1'b0;
    for (int i = 0; i < 20 && !busy; i++) cyc(1);
    reg_sw = 1'b1; inj_sw = 1'b1; cyc(1); reg_sw = 1'b0; inj_sw = 1'b0;
    wait_flag(1'b0, "R8");
    chk("R8", "first regular result", reg_data, 64'(s0[6:0]));
    chk("R8", "injected not done yet", jeoc, 0);
    eoc_clr = 1'b1; cyc(1); eoc_clr = 1'b0;
    wait_flag(1'b1, "R8");
    chk("R8", "injected served second", inj_data[15:0], 64'({1'b1, 2'd0, 7'(s0 + 1)}));
    chk("R8", "pending regular not yet done", eoc, 0);
    wait_flag(1'b0, "R8");
    chk("R8", "pending regular served last", reg_data, 64'(7'(s0 + 2)));
    pulse_clr();
  endtask

  task automatic t_flags();
    int s0;
    s0 = starts;
    reg_sw = 1'b1; cyc(1); reg_sw = 1'b0;
    for (int i = 0; i < 40 && !core_done; i++) cyc(1);
    eoc_clr = 1'b1; cyc(1); eoc_clr = 1'b0;
    chk("R9", "set beats clear", eoc, 1);
    chk("R9", "data on collision", reg_data, 64'(s0[6:0]));
    cyc(3);
    chk("R9", "eoc sticky", eoc, 1);
    reg_rd = 1'b1; cyc(1); reg_rd = 1'b0;
    chk("R9", "eoc cleared by read", eoc, 0);
    inj_sw = 1'b1; cyc(1); inj_sw = 1'b0;
    wait_flag(1'b1, "R9");
    cyc(3);
    chk("R9", "jeoc sticky", jeoc, 1);
    inj_rd = 1'b1; cyc(1); inj_rd = 1'b0;
    chk("R9", "jeoc cleared by read", jeoc, 0);
    inj_sw = 1'b1; cyc(1); inj_sw = 1'b0;
    wait_flag(1'b1, "R9");
    jeoc_clr = 1'b1; cyc(1); jeoc_clr = 1'b0;
    chk("R9", "jeoc cleared by W1C", jeoc, 0);
  endtask

  task automatic t_abort();
    logic [15:0] d0;
    d0 = reg_data;
    reg_sw = 1'b1; cyc(1); reg_sw = 1'b0;
    for (int i = 0; i < 20 && !busy; i++) cyc(1);
    cyc(1);
    wr_en(1'b0);
    chk("R5", "powered after abort", powered, 0);
    chk("R5", "ready after abort", ready, 0);
    chk("R5", "busy after abort", busy, 0);
    cyc(15);
    chk("R5", "no flag from aborted conversion", eoc, 0);
    chk("R5", "no data from aborted conversion", reg_data, 64'(d0));
  endtask

  initial begin
    cke = 1'b1; en_wr = 0; en_wdata = 0; reg_sw = 0; inj_sw = 0; reg_xen = 0; inj_xen = 0;
    reg_sel = 0; inj_sel = 0; reg_trig = 0; inj_trig = 0; inj_len = 0;
    eoc_clr = 0; jeoc_clr = 0; reg_rd = 0; inj_rd = 0;
    fork
      begin
        cyc(3); rst_n = 1'b1; cyc(1);
        t_reset();
        t_powerup();
        t_sw_start();
        t_ext_trig();
        t_inj_seq();
        t_inj_during_reg();
        t_flags();
        t_abort();
      end
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=expired expected=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule